// File: doc/BRIEF.md
# One-Shot Match Timer with Register Bus

This peripheral holds a counter that, once armed, steps toward a programmed match value by one on every cycle in which the tick-enable input is high. Software arms it by writing the match register. Counting starts from whatever value the counter shows at that moment. If the match value is not above that value, the count wraps through zero. When the count arrives at the match value, the counter stops there and the hit is recorded in a status flag. The flag drives a level interrupt, but only if the interrupt-enable register holds a nonzero value. Software acknowledges the interrupt by writing zero to the status register.

Internally the engine keeps the remaining distance to the match value. The counter reading is the match value minus that distance, so a running count and a stopped one read the same way.

All accesses are single-cycle word accesses. The register bus has no back-pressure: a write takes effect at the clock edge that samples it, and read data is valid during the same cycle the read request is presented. The tick input is a plain enable, so the block can run from any clock. A typical system drives it at 50 MHz.

Top module: `match_timer`

## Requirements
- R1: After reset the counter, match value, status flag and interrupt-enable value all read zero, `irq` is low, and the timer is idle.
- R2: The register offsets are fixed. Writing 0x00 loads the match value; reading 0x00 returns zero. Reading 0x10 returns the counter. Offset 0x14 is status, with the flag in bit 0. Offset 0x1C is interrupt enable, all 32 bits read back.
- R3: A write to the match register arms a count from the current counter reading c toward the new match value m. Only the low CNT_W bits of the write are kept. When m > c, the distance is m - c.
- R4: When m <= c, the distance wraps and equals m + (all-ones - c), taken modulo 2^CNT_W. Right after such an arm, the counter reads c + 1.
- R5: While armed, every cycle with `tick_en` high reduces the distance by one, so the counter reading advances by one toward m. Cycles with `tick_en` low change nothing.
- R6: The tick that finds a distance of one or zero is the hit. After that edge the counter equals m and stays frozen until the next match write, no matter how many ticks follow.
- R7: On a hit, the status flag is set only if the interrupt-enable value is nonzero. `irq` is a registered copy of the flag and rises at the edge that ends the hit cycle.
- R8: Writing zero to the status register clears the flag and drops `irq`. A nonzero write to status is ignored. If a hit and a clear happen in the same cycle, the hit wins.
- R9: If a match write and the final tick happen in the same cycle, the write wins. The count is re-armed from the current reading and no hit is recorded.
- R10: Writes to unmapped offsets change no register, and reads from them return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Count-step enable |
| bus_req | input | 1 | Access request, valid for one cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid in the request cycle |
| irq | output | 1 | Level interrupt, equal to the status flag |

## Verification
The bench uses an 8-bit counter so that wrapped counts complete in a few hundred ticks. The count is tried with four kinds of arm:
- A forward arm separates the plain m - c distance from the wrapped one.
- A wrapped arm exposes the c + 1 starting reading.
- An arm with m equal to c runs the longest count.
- An arm from all-ones to zero gives a zero distance, which must still hit on the next tick.
Same-cycle collisions are also driven. An arm collides with the final tick, which must suppress the hit. A status clear collides with a hit, which must keep the flag set. A run with interrupts disabled shows that the counter still stops while the flag stays clear.

// File: rtl/mt_pkg.sv
package mt_pkg;
  // Register offsets (bytes, word aligned)
  localparam int unsigned OFF_MATCH  = 32'h00;
  localparam int unsigned OFF_COUNT  = 32'h10;
  localparam int unsigned OFF_STATUS = 32'h14;
  localparam int unsigned OFF_INTEN  = 32'h1C;

  // Decoded write strobes produced by the register front end
  typedef struct packed {
    logic match_wr;
    logic status_wr;
    logic inten_wr;
  } mt_wr_strobe_t;
endpackage

// File: rtl/mt_regbus.sv
module mt_regbus
  import mt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  count_val,
  input  logic              stat_flag,
  input  logic [DATA_W-1:0] inten_val,
  output mt_wr_strobe_t     wr_stb,
  output logic [DATA_W-1:0] rdata
);
  localparam logic [ADDR_W-1:0] A_MATCH  = ADDR_W'(OFF_MATCH);
  localparam logic [ADDR_W-1:0] A_COUNT  = ADDR_W'(OFF_COUNT);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFF_STATUS);
  localparam logic [ADDR_W-1:0] A_INTEN  = ADDR_W'(OFF_INTEN);

  logic [DATA_W-1:0] count_ext;

  // Widen or trim the counter to the bus width
  generate
    if (CNT_W < DATA_W) begin : g_pad
      assign count_ext = {{(DATA_W-CNT_W){1'b0}}, count_val};
    end else begin : g_trim
      assign count_ext = count_val[DATA_W-1:0];
    end
  endgenerate

  logic wr_cyc, rd_cyc;
  assign wr_cyc = req & we;
  assign rd_cyc = req & ~we;

  always_comb begin
    wr_stb           = '0;
    wr_stb.match_wr  = wr_cyc && (addr == A_MATCH);
    wr_stb.status_wr = wr_cyc && (addr == A_STATUS);
    wr_stb.inten_wr  = wr_cyc && (addr == A_INTEN);
  end

  always_comb begin
    rdata = '0;
    if (rd_cyc) begin
      unique case (addr)
        A_COUNT:  rdata = count_ext;
        A_STATUS: rdata = DATA_W'(stat_flag);
        A_INTEN:  rdata = inten_val;
        default:  rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/mt_count_engine.sv
module mt_count_engine #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             arm,
  input  logic [CNT_W-1:0] arm_val,
  output logic [CNT_W-1:0] count_val,
  output logic [CNT_W-1:0] match_val,
  output logic [CNT_W-1:0] remain_val,
  output logic             running,
  output logic             hit
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] match_q, remain_q, dist_new;
  logic             run_q;

  // Live reading: target minus what is left to go
  assign count_val = match_q - remain_q;

  // Distance for a fresh arm, wrapping through zero when not ahead
  always_comb begin
    if (arm_val > count_val) dist_new = arm_val - count_val;
    else                     dist_new = arm_val + ~count_val;
  end

  // A write in the same cycle overrides the final tick
  assign hit = run_q && tick_en && !arm && (remain_q <= ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_q  <= '0;
      remain_q <= '0;
      run_q    <= 1'b0;
    end else if (arm) begin
      match_q  <= arm_val;
      remain_q <= dist_new;
      run_q    <= 1'b1;
    end else if (hit) begin
      remain_q <= '0;
      run_q    <= 1'b0;
    end else if (run_q && tick_en) begin
      remain_q <= remain_q - ONE;
    end
  end

  assign match_val  = match_q;
  assign remain_val = remain_q;
  assign running    = run_q;
endmodule

// File: rtl/mt_irq_ctrl.sv
module mt_irq_ctrl #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit,
  input  logic              inten_wr,
  input  logic              status_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] inten_val,
  output logic              stat_flag
);
  logic [DATA_W-1:0] inten_q;
  logic              stat_q;
  logic              set_ev, clr_ev;

  assign set_ev = hit && (inten_q != '0);
  assign clr_ev = status_wr && (wdata == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) inten_q <= '0;
    else if (inten_wr) inten_q <= wdata;
  end

  // Set beats clear when both land together
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      stat_q <= 1'b0;
    else if (set_ev) stat_q <= 1'b1;
    else if (clr_ev) stat_q <= 1'b0;
  end

  assign inten_val = inten_q;
  assign stat_flag = stat_q;
endmodule

// File: rtl/match_timer.sv
module match_timer
  import mt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  mt_wr_strobe_t     wr_stb;
  logic [CNT_W-1:0]  cnt_live, eng_match, eng_remain, arm_data;
  logic              eng_running, eng_hit, stat_q;
  logic [DATA_W-1:0] en_val;

  generate
    if (CNT_W < DATA_W) begin : g_arm_trim
      assign arm_data = bus_wdata[CNT_W-1:0];
    end else begin : g_arm_pad
      assign arm_data = CNT_W'(bus_wdata);
    end
  endgenerate

  mt_regbus #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_bus (
    .req       (bus_req),
    .we        (bus_we),
    .addr      (bus_addr),
    .count_val (cnt_live),
    .stat_flag (stat_q),
    .inten_val (en_val),
    .wr_stb    (wr_stb),
    .rdata     (bus_rdata)
  );

  mt_count_engine #(.CNT_W(CNT_W)) u_eng (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_en    (tick_en),
    .arm        (wr_stb.match_wr),
    .arm_val    (arm_data),
    .count_val  (cnt_live),
    .match_val  (eng_match),
    .remain_val (eng_remain),
    .running    (eng_running),
    .hit        (eng_hit)
  );

  mt_irq_ctrl #(.DATA_W(DATA_W)) u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .hit       (eng_hit),
    .inten_wr  (wr_stb.inten_wr),
    .status_wr (wr_stb.status_wr),
    .wdata     (bus_wdata),
    .inten_val (en_val),
    .stat_flag (stat_q)
  );

  assign irq = stat_q;
endmodule

// File: rtl/mt_timer_chk.sv
module mt_timer_chk #(
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_en,
  input logic              arm,
  input logic              st_wr,
  input logic [DATA_W-1:0] wdata,
  input logic [CNT_W-1:0]  count_val,
  input logic [CNT_W-1:0]  match_val,
  input logic [CNT_W-1:0]  remain,
  input logic              running,
  input logic [DATA_W-1:0] en_val,
  input logic              irq
);
  logic final_tick;
  assign final_tick = running && tick_en && !arm && (remain <= CNT_W'(1));

  // R3
  arm_runs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> running);

  // R5
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running && tick_en && !arm && (remain > CNT_W'(1))
    |=> count_val == $past(count_val) + CNT_W'(1));

  // R6
  hit_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    final_tick |=> !running && (count_val == $past(match_val)));

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !running && !arm |=> $stable(count_val));

  // R7
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(en_val != '0) && $past(final_tick));

  // R8
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_wr && (wdata == '0) && !final_tick |=> !irq);

  // R9
  arm_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arm && !irq |=> !irq);
endmodule

bind match_timer mt_timer_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick_en   (tick_en),
  .arm       (wr_stb.match_wr),
  .st_wr     (wr_stb.status_wr),
  .wdata     (bus_wdata),
  .count_val (cnt_live),
  .match_val (eng_match),
  .remain    (eng_remain),
  .running   (eng_running),
  .en_val    (en_val),
  .irq       (irq)
);

// File: tb/match_timer_tb.sv
`timescale 1ns/1ps
module match_timer_tb;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 8;
  localparam logic [7:0] A_MATCH = 8'h00, A_COUNT = 8'h10,
                         A_STAT = 8'h14, A_INTEN = 8'h1C;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_en = 1'b0;
  logic bus_req = 1'b0;
  logic bus_we = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic [DATA_W-1:0] bus_rdata;
  logic irq;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  logic [DATA_W-1:0] exp_q[$];
  string             tag_q[$];

  always #2.5 clk = ~clk;

  match_timer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_req(bus_req),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  // Monitor: compares each read against the scoreboard
  always @(negedge clk) begin
    if (rst_n && bus_req && !bus_we) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL scoreboard: read with no expected item, actual %h expected none", bus_rdata);
      end else begin
        logic [DATA_W-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (bus_rdata !== e) begin
          fails++;
          $display("FAIL %s: actual %h expected %h", t, bus_rdata, e);
        end
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [DATA_W-1:0] d);
    bus_req = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_req = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [DATA_W-1:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
    bus_req = 1; bus_we = 0; bus_addr = a;
    @(posedge clk); #1;
    bus_req = 0;
  endtask

  task automatic ticks(input int n);
    tick_en = 1;
    repeat (n) @(posedge clk);
    #1; tick_en = 0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    checks++;
    if (irq !== e) begin
      fails++;
      $display("FAIL %s: irq actual %b expected %b", t, irq, e);
    end
  endtask

  initial begin
    #(100000 * 5);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(posedge clk); #1;
    // R1 reset state
    rd(A_COUNT, 0, "R1 counter");
    rd(A_STAT, 0, "R1 status");
    rd(A_INTEN, 0, "R1 inten");
    chk_irq(0, "R1 irq");
    // R2 enable readback, full width
    wr(A_INTEN, 32'hA5A5_0001);
    rd(A_INTEN, 32'hA5A5_0001, "R2 inten readback");
    // R3 forward arm 0 -> 5 (upper bits dropped)
    wr(A_MATCH, 32'h0000_0305);
    rd(A_COUNT, 0, "R3 reading after arm");
    rd(A_MATCH, 0, "R2 match reads zero");
    ticks(3);
    rd(A_COUNT, 3, "R5 after 3 ticks");
    chk_irq(0, "R7 no irq before hit");
    ticks(2);
    rd(A_COUNT, 5, "R6 counter at match");
    rd(A_STAT, 1, "R7 status set");
    chk_irq(1, "R7 irq raised");
    ticks(4);
    rd(A_COUNT, 5, "R6 frozen after hit");
    // R8 nonzero write ignored, zero clears
    wr(A_STAT, 7);
    rd(A_STAT, 1, "R8 nonzero write ignored");
    wr(A_STAT, 0);
    rd(A_STAT, 0, "R8 cleared");
    chk_irq(0, "R8 irq low");
    wr(A_STAT, 0);
    rd(A_STAT, 0, "R8 clear when clear");
    // R10 unmapped
    wr(8'h08, 32'hFF);
    wr(8'h18, 32'h0);
    rd(8'h08, 0, "R10 unmapped read");
    rd(A_COUNT, 5, "R10 counter untouched");
    rd(A_INTEN, 32'hA5A5_0001, "R10 inten untouched");
    // R4 wrap arm 5 -> 3: distance 253, reading 6
    wr(A_MATCH, 3);
    rd(A_COUNT, 6, "R4 wrap start reading");
    ticks(252);
    rd(A_COUNT, 2, "R4 one before match");
    chk_irq(0, "R4 no early hit");
    ticks(1);
    rd(A_COUNT, 3, "R4 wrapped hit");
    chk_irq(1, "R4 irq");
    wr(A_STAT, 0);
    // R7 disabled: count stops, no flag
    wr(A_INTEN, 0);
    wr(A_MATCH, 10);
    ticks(7);
    rd(A_COUNT, 10, "R7 stops when disabled");
    rd(A_STAT, 0, "R7 no flag when disabled");
    chk_irq(0, "R7 irq stays low");
    // R9 arm beats final tick
    wr(A_INTEN, 1);
    wr(A_MATCH, 12);
    ticks(1);
    rd(A_COUNT, 11, "R9 before collision");
    tick_en = 1;
    wr(A_MATCH, 20);
    tick_en = 0;
    rd(A_COUNT, 11, "R9 re-armed, tick ignored");
    rd(A_STAT, 0, "R9 hit suppressed");
    ticks(9);
    rd(A_COUNT, 20, "R9 new match reached");
    chk_irq(1, "R9 irq on new match");
    wr(A_STAT, 0);
    // R4 equal arm: full-range count
    wr(A_MATCH, 20);
    rd(A_COUNT, 21, "R4 equal arm start");
    ticks(254);
    rd(A_COUNT, 19, "R4 equal arm near end");
    ticks(1);
    rd(A_COUNT, 20, "R4 equal arm hit");
    wr(A_STAT, 0);
    // R6 zero distance: all-ones to zero
    wr(A_MATCH, 255);
    ticks(235);
    rd(A_COUNT, 255, "R3 reach all-ones");
    wr(A_STAT, 0);
    wr(A_MATCH, 0);
    rd(A_COUNT, 0, "R6 zero distance reading");
    chk_irq(0, "R6 not yet hit");
    ticks(1);
    rd(A_STAT, 1, "R6 zero distance hits");
    wr(A_STAT, 0);
    // R8 hit and clear in same cycle: set wins
    wr(A_MATCH, 2);
    ticks(1);
    tick_en = 1;
    wr(A_STAT, 0);
    tick_en = 0;
    rd(A_STAT, 1, "R8 hit beats clear");
    rd(A_COUNT, 2, "R8 counter at match");
    repeat (2) @(posedge clk);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule